// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block decides which frequency setting a clock synthesizer runs from. It captures five frequency strap pins and a current-multiplier strap once, when the active-low power-good strobe is first seen low. It then chooses among three sources. The first is a table index taken either from those latched straps or from a software select code. The second is a programmable N/M divider pair. The third is a recovery setting that applies while a watchdog requests recovery.

The chosen setting is held in registers and presented to the synthesizer. It consists of a 5-bit ratio/gear index, the effective N and M values, and a flag that says N/M is in use. The synthesizer's output is G*(N+3)/(M+3), so a pair is only usable when N is greater than M. Whenever the registered setting changes, the block emits a one-cycle change pulse. If software has enabled it, the block also drives an open-drain system reset for a fixed number of cycles. The latched straps are readable, and the selected drive-current multiplier code is available as an output.

Top module: `freq_src_sel`

## Requirements
- R1: The straps `strap_fs` and `strap_mul` are captured on the first rising clock edge after reset at which `pgood_n` is 0. From that edge on, `strap_valid` is 1 and `strap_rb` shows the captured code. Later values of `pgood_n` and of the straps have no effect until the next reset.
- R2: With `prog_en`=0 and `rec_req`=0, `gear_idx` equals the latched strap code when `code_ovr`=0 and equals `sw_code` when `code_ovr`=1. In this case `nm_mode`=0 and `eff_n`=`eff_m`=0. Outputs follow the inputs one clock after they are applied.
- R3: With `prog_en`=1, `rec_req`=0 and a valid pair held, `nm_mode`=1 and `eff_n`/`eff_m` show the held pair. `gear_idx` still follows `code_ovr` as in R2.
- R4: A write whose N is not greater than M (that is, N+3 <= M+3) is rejected. The previously held pair is kept and `nm_invalid` is set. A later valid write clears `nm_invalid`. Until a valid pair has been held, programmable mode falls back to the selection of R2.
- R5: The held N/M pair changes only on a cycle in which `prog_wr` is 1. Changing `prog_n`/`prog_m` without that strobe leaves `eff_n`/`eff_m` unchanged.
- R6: While `rec_req`=1 and `rec_sel`=0, `gear_idx` is the latched strap code and `nm_mode`=0. This holds regardless of `prog_en` and `code_ovr`.
- R7: While `rec_req`=1 and `rec_sel`=1, `eff_n`/`eff_m` are `rec_n`/`rec_m` with `nm_mode`=1, and `gear_idx` follows `code_ovr`. If `rec_n` is not greater than `rec_m`, the selection of R6 applies instead.
- R8: `chg_pulse` is 1 for exactly the cycle in which the registered setting first shows a new value. The first load after the straps are captured does not raise it.
- R9: With `rst_on_chg`=1, each change pulse makes `sysrst_oe` (1 = pull the reset line low) go high on the next cycle for exactly RST_LEN cycles. With `rst_on_chg`=0, the pulse leaves `sysrst_oe` at 0.
- R10: `mul_code` encodes the multiplier as 0=4x, 1=5x, 2=6x, 3=7x. With `mul_ovr`=0, it is 2 when the latched multiplier strap is 1 and 0 when it is 0. With `mul_ovr`=1, it equals `sw_mul`.
- R11: In reset, all registered outputs are 0: `gear_idx`, `eff_n`, `eff_m`, `nm_mode`, `chg_pulse`, `sysrst_oe`, `nm_invalid`, `strap_rb` and `strap_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pgood_n | input | 1 | Active-low power-good strobe that qualifies the straps |
| strap_fs | input | 5 | Frequency select straps |
| strap_mul | input | 1 | Current-multiplier strap |
| code_ovr | input | 1 | 1 selects sw_code as the ratio/gear index |
| sw_code | input | 5 | Software frequency select code |
| prog_en | input | 1 | Enables programmable N/M mode |
| prog_n | input | 8 | Programmable N value |
| prog_m | input | 7 | Programmable M value |
| prog_wr | input | 1 | Strobe: N or M register written |
| rec_req | input | 1 | Recovery request from the watchdog (level) |
| rec_sel | input | 1 | Recovery source: 0 straps, 1 recovery N/M |
| rec_n | input | 8 | Recovery N value |
| rec_m | input | 7 | Recovery M value |
| rst_on_chg | input | 1 | Enables a reset pulse on frequency change |
| mul_ovr | input | 1 | 1 selects sw_mul as the multiplier code |
| sw_mul | input | 2 | Software multiplier code |
| gear_idx | output | 5 | Active ratio/gear table index |
| eff_n | output | 8 | Effective N (0 when nm_mode is 0) |
| eff_m | output | 7 | Effective M (0 when nm_mode is 0) |
| nm_mode | output | 1 | 1 when the N/M pair sets the frequency |
| chg_pulse | output | 1 | One-cycle pulse on a setting change |
| sysrst_oe | output | 1 | Open-drain enable for the system reset line |
| nm_invalid | output | 1 | Last programmable write was rejected |
| strap_rb | output | 5 | Readback of the latched frequency straps |
| strap_valid | output | 1 | Straps have been captured |
| mul_code | output | 2 | Selected current-multiplier code |

## Verification
The bench sweeps all 32 strap codes through capture, and then toggles the power-good strobe and the straps again. A latch that keeps following `pgood_n` would show a changed readback and a changed index. Every software code is swept with and without override, and an 8x8 grid of N/M writes covers the equal and inverted pairs. A design that accepted N=M would change `eff_n` and clear `nm_invalid`. The recovery paths are tested with a valid pair and an invalid pair, which catches a design that applies a bad recovery ratio or lets override leak into the strap fallback. The reset pulse is counted cycle by cycle to catch an off-by-one length and a pulse that fires while disabled.

// File: rtl/freq_src_pkg.sv
// Shared widths, setting type and ratio check for the frequency source selector.
package freq_src_pkg;
    parameter int GEAR_W = 5;
    parameter int N_W    = 8;
    parameter int M_W    = 7;
    parameter int MUL_W  = 2;

    // One complete frequency setting as presented to the synthesizer.
    typedef struct packed {
        logic [GEAR_W-1:0] gear;
        logic [N_W-1:0]    n;
        logic [M_W-1:0]    m;
        logic              nm;
    } freq_set_t;

    // True when (n+3)/(m+3) > 1, i.e. n strictly greater than m.
    function automatic logic ratio_ok(input logic [N_W-1:0] n, input logic [M_W-1:0] m);
        return n > {{(N_W-M_W){1'b0}}, m};
    endfunction
endpackage

// File: rtl/strap_latch.sv
// Captures the strap pins once, on the first edge where power-good is low.
// Assumes straps are stable while pgood_n is low; afterwards inputs are ignored.
module strap_latch
    import freq_src_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgood_n,
    input  logic [GEAR_W-1:0] fs_in,
    input  logic              mul_in,
    output logic [GEAR_W-1:0] fs_q,
    output logic              mul_q,
    output logic              valid
);
    // One-shot capture of the straps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q  <= '0;
            mul_q <= 1'b0;
            valid <= 1'b0;
        end else if (!valid && !pgood_n) begin
            fs_q  <= fs_in;
            mul_q <= mul_in;
            valid <= 1'b1;
        end
    end
endmodule

// File: rtl/nm_holder.sv
// Holds the programmable N/M pair; accepts a write only if N > M.
// Assumes wr is a single-cycle strobe per register update.
module nm_holder
    import freq_src_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [N_W-1:0] n_in,
    input  logic [M_W-1:0] m_in,
    output logic [N_W-1:0] n_q,
    output logic [M_W-1:0] m_q,
    output logic           hold_ok,
    output logic           invalid
);
    // Update held pair or flag a rejected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q     <= '0;
            m_q     <= '0;
            hold_ok <= 1'b0;
            invalid <= 1'b0;
        end else if (wr) begin
            if (ratio_ok(n_in, m_in)) begin
                n_q     <= n_in;
                m_q     <= m_in;
                hold_ok <= 1'b1;
                invalid <= 1'b0;
            end else begin
                invalid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sel_arbiter.sv
// Chooses recovery, programmable or table setting and registers it.
// Assumes straps valid before any setting is loaded; first load is silent.
module sel_arbiter
    import freq_src_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_ok,
    input  logic [GEAR_W-1:0] fs_q,
    input  logic              code_ovr,
    input  logic [GEAR_W-1:0] sw_code,
    input  logic              prog_en,
    input  logic              hold_ok,
    input  logic [N_W-1:0]    hold_n,
    input  logic [M_W-1:0]    hold_m,
    input  logic              rec_req,
    input  logic              rec_sel,
    input  logic [N_W-1:0]    rec_n,
    input  logic [M_W-1:0]    rec_m,
    output freq_set_t         cur,
    output logic              chg
);
    logic [GEAR_W-1:0] ratio_code;
    freq_set_t         nxt;
    logic              armed;

    assign ratio_code = code_ovr ? sw_code : fs_q;

    // Priority: recovery, then programmable, then table selection.
    always_comb begin
        nxt = '{gear: ratio_code, n: '0, m: '0, nm: 1'b0};
        if (rec_req) begin
            if (rec_sel && ratio_ok(rec_n, rec_m)) begin
                nxt = '{gear: ratio_code, n: rec_n, m: rec_m, nm: 1'b1};
            end else begin
                nxt.gear = fs_q;
            end
        end else if (prog_en && hold_ok) begin
            nxt = '{gear: ratio_code, n: hold_n, m: hold_m, nm: 1'b1};
        end
    end

    // Register the setting and flag changes after the first load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur   <= '0;
            armed <= 1'b0;
            chg   <= 1'b0;
        end else if (strap_ok) begin
            cur   <= nxt;
            armed <= 1'b1;
            chg   <= armed && (nxt != cur);
        end else begin
            chg   <= 1'b0;
        end
    end
endmodule

// File: rtl/rst_pulse.sv
// Stretches a change pulse into an open-drain reset enable of LEN cycles.
// Assumes trig is a single-cycle pulse; a new trigger restarts the count.
module rst_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic en,
    output logic oe
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] cnt;

    // Load on trigger, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (trig && en) begin
            cnt <= CW'(LEN);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign oe = (cnt != '0);
endmodule

// File: rtl/freq_src_sel.sv
// Top: frequency source selection for a clock synthesizer.
// Assumes all register-field inputs are synchronous to clk.
module freq_src_sel
    import freq_src_pkg::*;
#(
    parameter int RST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgood_n,
    input  logic [GEAR_W-1:0] strap_fs,
    input  logic              strap_mul,
    input  logic              code_ovr,
    input  logic [GEAR_W-1:0] sw_code,
    input  logic              prog_en,
    input  logic [N_W-1:0]    prog_n,
    input  logic [M_W-1:0]    prog_m,
    input  logic              prog_wr,
    input  logic              rec_req,
    input  logic              rec_sel,
    input  logic [N_W-1:0]    rec_n,
    input  logic [M_W-1:0]    rec_m,
    input  logic              rst_on_chg,
    input  logic              mul_ovr,
    input  logic [MUL_W-1:0]  sw_mul,
    output logic [GEAR_W-1:0] gear_idx,
    output logic [N_W-1:0]    eff_n,
    output logic [M_W-1:0]    eff_m,
    output logic              nm_mode,
    output logic              chg_pulse,
    output logic              sysrst_oe,
    output logic              nm_invalid,
    output logic [GEAR_W-1:0] strap_rb,
    output logic              strap_valid,
    output logic [MUL_W-1:0]  mul_code
);
    localparam logic [MUL_W-1:0] MUL_4X = MUL_W'(0);
    localparam logic [MUL_W-1:0] MUL_6X = MUL_W'(2);

    logic [GEAR_W-1:0] fs_q;
    logic              mul_q;
    logic [N_W-1:0]    hold_n;
    logic [M_W-1:0]    hold_m;
    logic              hold_ok;
    freq_set_t         cur;

    strap_latch u_strap (
        .clk(clk), .rst_n(rst_n), .pgood_n(pgood_n),
        .fs_in(strap_fs), .mul_in(strap_mul),
        .fs_q(fs_q), .mul_q(mul_q), .valid(strap_valid)
    );

    nm_holder u_hold (
        .clk(clk), .rst_n(rst_n), .wr(prog_wr),
        .n_in(prog_n), .m_in(prog_m),
        .n_q(hold_n), .m_q(hold_m), .hold_ok(hold_ok), .invalid(nm_invalid)
    );

    sel_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .strap_ok(strap_valid), .fs_q(fs_q),
        .code_ovr(code_ovr), .sw_code(sw_code), .prog_en(prog_en),
        .hold_ok(hold_ok), .hold_n(hold_n), .hold_m(hold_m),
        .rec_req(rec_req), .rec_sel(rec_sel), .rec_n(rec_n), .rec_m(rec_m),
        .cur(cur), .chg(chg_pulse)
    );

    rst_pulse #(.LEN(RST_LEN)) u_rst (
        .clk(clk), .rst_n(rst_n), .trig(chg_pulse), .en(rst_on_chg), .oe(sysrst_oe)
    );

    assign gear_idx = cur.gear;
    assign eff_n    = cur.n;
    assign eff_m    = cur.m;
    assign nm_mode  = cur.nm;
    assign strap_rb = fs_q;
    assign mul_code = mul_ovr ? sw_mul : (mul_q ? MUL_6X : MUL_4X);
endmodule

// File: rtl/freq_src_sel_chk.sv
// Checker for freq_src_sel: temporal properties over its ports.
module freq_src_sel_chk
    import freq_src_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rec_req,
    input logic              rec_sel,
    input logic [GEAR_W-1:0] strap_rb,
    input logic              strap_valid,
    input logic [N_W-1:0]    eff_n,
    input logic [M_W-1:0]    eff_m,
    input logic              nm_mode,
    input logic              chg_pulse,
    input logic              sysrst_oe
);
    assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_valid && $past(strap_valid)) |-> $stable(strap_rb));

    assert_nm_zero_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !nm_mode |-> (eff_n == '0 && eff_m == '0));

    assert_ratio_gt_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nm_mode |-> (eff_n > {{(N_W-M_W){1'b0}}, eff_m}));

    assert_rec_strap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rec_req && !rec_sel) && $past(strap_valid)) |-> !nm_mode);

    assert_chg_needs_straps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |-> strap_valid);

    assert_rst_after_chg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysrst_oe) |-> $past(chg_pulse));
endmodule

bind freq_src_sel freq_src_sel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rec_req(rec_req), .rec_sel(rec_sel),
    .strap_rb(strap_rb), .strap_valid(strap_valid), .eff_n(eff_n), .eff_m(eff_m),
    .nm_mode(nm_mode), .chg_pulse(chg_pulse), .sysrst_oe(sysrst_oe)
);

// File: tb/freq_src_sel_tb.sv
module freq_src_sel_tb;
    localparam int RST_LEN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pgood_n = 1'b1;
    logic [4:0] strap_fs = '0;
    logic       strap_mul = 1'b0;
    logic       code_ovr = 1'b0;
    logic [4:0] sw_code = '0;
    logic       prog_en = 1'b0;
    logic [7:0] prog_n = '0;
    logic [6:0] prog_m = '0;
    logic       prog_wr = 1'b0;
    logic       rec_req = 1'b0;
    logic       rec_sel = 1'b0;
    logic [7:0] rec_n = '0;
    logic [6:0] rec_m = '0;
    logic       rst_on_chg = 1'b0;
    logic       mul_ovr = 1'b0;
    logic [1:0] sw_mul = '0;
    logic [4:0] gear_idx;
    logic [7:0] eff_n;
    logic [6:0] eff_m;
    logic       nm_mode, chg_pulse, sysrst_oe, nm_invalid, strap_valid;
    logic [4:0] strap_rb;
    logic [1:0] mul_code;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    freq_src_sel #(.RST_LEN(RST_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .pgood_n(pgood_n), .strap_fs(strap_fs),
        .strap_mul(strap_mul), .code_ovr(code_ovr), .sw_code(sw_code),
        .prog_en(prog_en), .prog_n(prog_n), .prog_m(prog_m), .prog_wr(prog_wr),
        .rec_req(rec_req), .rec_sel(rec_sel), .rec_n(rec_n), .rec_m(rec_m),
        .rst_on_chg(rst_on_chg), .mul_ovr(mul_ovr), .sw_mul(sw_mul),
        .gear_idx(gear_idx), .eff_n(eff_n), .eff_m(eff_m), .nm_mode(nm_mode),
        .chg_pulse(chg_pulse), .sysrst_oe(sysrst_oe), .nm_invalid(nm_invalid),
        .strap_rb(strap_rb), .strap_valid(strap_valid), .mul_code(mul_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Reset, then capture the given straps (two edges after capture: setting loaded).
    task automatic latch(input logic [4:0] fs, input logic mul);
        rst_n = 1'b0; pgood_n = 1'b1; strap_fs = fs; strap_mul = mul;
        step(); step();
        rst_n = 1'b1;
        step();
        pgood_n = 1'b0;
        step();
        step();
    endtask

    task automatic run_all();
        logic [4:0] prev;
        logic [7:0] hn;
        logic [6:0] hm;
        logic       hok;
        int         cnt;

        // R11: reset state
        step(); step();
        chk("R11 gear", gear_idx, 0);
        chk("R11 eff_n", eff_n, 0);
        chk("R11 nm_mode", nm_mode, 0);
        chk("R11 chg", chg_pulse, 0);
        chk("R11 oe", sysrst_oe, 0);
        chk("R11 valid", strap_valid, 0);
        chk("R11 rb", strap_rb, 0);
        chk("R11 invalid", nm_invalid, 0);

        // R1/R2/R8/R10: sweep every strap code
        for (int s = 0; s < 32; s++) begin
            rst_n = 1'b0; pgood_n = 1'b1; strap_fs = 5'(s); strap_mul = s[0];
            step(); step();
            rst_n = 1'b1;
            step();
            chk("R1 not valid before pgood", strap_valid, 0);
            pgood_n = 1'b0;
            step();
            chk("R1 valid", strap_valid, 1);
            chk("R1 rb", strap_rb, s);
            step();
            chk("R8 no pulse on first load", chg_pulse, 0);
            strap_fs = ~5'(s); strap_mul = ~s[0]; pgood_n = 1'b1;
            step();
            pgood_n = 1'b0;
            step(); step();
            chk("R1 straps ignored", strap_rb, s);
            chk("R2 gear from straps", gear_idx, s);
            chk("R2 nm off", nm_mode, 0);
            chk("R10 mul from strap", mul_code, s[0] ? 2 : 0);
        end

        // R2/R8: software code sweep with override
        latch(5'd5, 1'b0);
        code_ovr = 1'b1;
        prev = 5'd5;
        for (int v = 0; v < 32; v++) begin
            sw_code = 5'(v);
            step();
            chk("R2 gear from sw_code", gear_idx, v);
            chk("R8 pulse on change", chg_pulse, (5'(v) != prev) ? 1 : 0);
            prev = 5'(v);
        end
        code_ovr = 1'b0;
        step();
        chk("R2 back to straps", gear_idx, 5);

        // R10: software multiplier
        mul_ovr = 1'b1;
        for (int v = 0; v < 4; v++) begin
            sw_mul = 2'(v);
            #1;
            chk("R10 sw mul", mul_code, v);
        end
        mul_ovr = 1'b0;
        #1;
        chk("R10 strap mul 4x", mul_code, 0);

        // R3/R4: programmable grid
        prog_en = 1'b1;
        step();
        chk("R4 fallback before valid pair", nm_mode, 0);
        hn = '0; hm = '0; hok = 1'b0;
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 8; m++) begin
                prog_n = 8'(n); prog_m = 7'(m); prog_wr = 1'b1;
                step();
                prog_wr = 1'b0;
                step();
                if (n > m) begin hn = 8'(n); hm = 7'(m); hok = 1'b1; end
                chk("R4 invalid flag", nm_invalid, (n <= m) ? 1 : 0);
                chk("R3 nm_mode", nm_mode, hok);
                chk("R3 eff_n", eff_n, hok ? hn : 0);
                chk("R3 eff_m", eff_m, hok ? hm : 0);
                chk("R3 gear", gear_idx, 5);
            end
        end
        prog_n = 8'd255; prog_m = 7'd127; prog_wr = 1'b1;
        step();
        prog_wr = 1'b0;
        step();
        chk("R4 max pair n", eff_n, 255);
        chk("R4 max pair m", eff_m, 127);
        code_ovr = 1'b1; sw_code = 5'd9;
        step();
        chk("R3 gear follows override", gear_idx, 9);
        chk("R3 nm kept", nm_mode, 1);

        // R5: no write strobe, no change
        prog_n = 8'd200; prog_m = 7'd3;
        step(); step();
        chk("R5 n unchanged", eff_n, 255);
        chk("R5 m unchanged", eff_m, 127);

        // R6/R7: recovery
        rec_req = 1'b1; rec_sel = 1'b0;
        step();
        chk("R6 nm off", nm_mode, 0);
        chk("R6 gear straps", gear_idx, 5);
        rec_sel = 1'b1; rec_n = 8'd100; rec_m = 7'd93;
        step();
        chk("R7 nm on", nm_mode, 1);
        chk("R7 rec n", eff_n, 100);
        chk("R7 rec m", eff_m, 93);
        chk("R7 gear override", gear_idx, 9);
        rec_n = 8'd50; rec_m = 7'd60;
        step();
        chk("R7 bad pair nm", nm_mode, 0);
        chk("R7 bad pair gear", gear_idx, 5);
        rec_req = 1'b0;
        step();
        chk("R7 exit n", eff_n, 255);
        chk("R7 exit gear", gear_idx, 9);

        // R9: reset pulse enabled
        rst_on_chg = 1'b1; sw_code = 5'd12;
        step();
        chk("R8 pulse", chg_pulse, 1);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (sysrst_oe) cnt++;
        end
        chk("R9 pulse length", cnt, RST_LEN);
        // R9: disabled
        rst_on_chg = 1'b0; sw_code = 5'd13;
        step();
        chk("R8 pulse 2", chg_pulse, 1);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (sysrst_oe) cnt++;
        end
        chk("R9 disabled no pulse", cnt, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule